// File: doc/BRIEF.md
# PS/2 Device-Side Byte Transmitter

This block is the device end of a PS/2 link in the device-to-host direction. Device logic pushes bytes into a small queue, each marked with an end-of-chunk flag. The block generates the link clock itself and sends each queued byte as an 11-bit frame. It drives both lines open-collector through two pull-low enables. The sampled line levels come back in through a two-stage synchronizer.

A frame starts only after both lines have read high for an unbroken qualification interval. The host may hold the clock line low at any time. The device detects this while it has the clock released. If the host does so after at least one falling edge of a frame but before the eleventh, the frame is abandoned and the whole chunk is sent again from its first byte. A chunk leaves the queue only when its last byte has completed all eleven clock pulses.

Timing is counted in microsecond ticks from a parameterised divider of the system clock. Each clock half-period is 40 us. Data moves 20 us into each high phase, which is 20 us ahead of the next falling edge.

Top module: `ps2_dev_tx`

## Requirements
- R1: After reset both pull-low enables are 0 and the full flag is 0.
- R2: Each byte is sent as 11 device clock pulses. The bits, in order, are a 0 start bit, the 8 data bits least significant first, an odd parity bit (data ones plus parity is odd) and a 1 stop bit. The host samples each bit at a falling clock edge.
- R3: The queue holds 16 bytes. The full flag is 1 exactly while 16 bytes are held that belong to unfinished chunks. A push while full is dropped and never sent.
- R4: A frame starts only after the clock and data lines have both read high continuously for 50 us. The start bit therefore appears no sooner than 70 us after the host releases the clock.
- R5: While the host holds the clock line low, the device drives neither line and queued bytes wait.
- R6: Every generated clock low phase and high phase within a frame lasts 40 us.
- R7: The data enable changes only while the clock is released. Each change is 20 us after the rising edge and 20 us before the next falling edge.
- R8: If the host holds the clock low after the first falling edge of a frame and before the eleventh, the device releases both lines. It then re-sends the current chunk from its first byte once the bus is idle again.
- R9: If the host holds the clock low before the first falling edge of a frame, only that byte is sent again. Earlier bytes of the chunk are not repeated.
- R10: A byte whose eleventh falling edge has occurred counts as delivered. An inhibit after that edge causes no re-send.
- R11: Bytes leave in the order they were pushed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tx_byte | input | 8 | Byte to queue |
| tx_push | input | 1 | Queue strobe for tx_byte |
| tx_last | input | 1 | Marks tx_byte as the final byte of its chunk |
| ps2_clk_in | input | 1 | Level read back from the clock line |
| ps2_dat_in | input | 1 | Level read back from the data line |
| ps2_clk_oe | output | 1 | 1 pulls the clock line low |
| ps2_dat_oe | output | 1 | 1 pulls the data line low |
| fifo_full | output | 1 | Queue holds 16 uncommitted bytes |

## Verification
Some properties are checked on every cycle:
- data moves only while the clock is released;
- a frame begins only on an idle bus;
- an abort leaves both lines released;
- a rewind lands the read pointer on the chunk start;
- a refused push leaves the queue level unchanged.

Other behaviour shows only in the bench's scenarios, which place host inhibits before the first falling edge, in mid-frame and after the last falling edge:
- the bit content and order on the wire;
- the exact 40 us and 20 us intervals;
- the 50 us qualification delay;
- whether a chunk is replayed in full, in part or not at all.

// File: rtl/ps2tx_pkg.sv
`timescale 1ns/1ps
package ps2tx_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_HIGH = 2'd1,
    ST_LOW  = 2'd2
  } tx_state_t;

  localparam int FRAME_BITS = 11;

  function automatic logic [FRAME_BITS-1:0] build_frame(input logic [7:0] b);
    return {1'b1, ~^b, b, 1'b0};
  endfunction
endpackage

// File: rtl/ps2tx_tick.sv
`timescale 1ns/1ps
module ps2tx_tick #(
  parameter int CLKS_PER_US = 125
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = $clog2(CLKS_PER_US + 1);
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_US - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else if (cnt == LAST) begin
      cnt  <= '0;
      tick <= 1'b1;
    end else begin
      cnt  <= cnt + CW'(1);
      tick <= 1'b0;
    end
  end
endmodule

// File: rtl/ps2tx_fifo.sv
`timescale 1ns/1ps
module ps2tx_fifo #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    push,
  input  logic [WIDTH-1:0]        din,
  input  logic                    din_last,
  input  logic                    pop,
  input  logic                    rewind,
  output logic [WIDTH-1:0]        dout,
  output logic                    have_byte,
  output logic                    full,
  output logic [$clog2(DEPTH):0]  fill,
  output logic [$clog2(DEPTH):0]  rd_ptr,
  output logic [$clog2(DEPTH):0]  base_ptr
);
  localparam int AW = $clog2(DEPTH);
  localparam int PW = AW + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  logic [WIDTH:0]  mem [DEPTH];
  logic [PW-1:0]   wr;
  logic            dout_last;
  logic            accept;

  assign fill      = wr - base_ptr;
  assign full      = (fill == DEPTH_P);
  assign have_byte = (rd_ptr != wr);
  assign accept    = push && !full;
  assign {dout_last, dout} = mem[rd_ptr[AW-1:0]];

  always_ff @(posedge clk) begin
    if (accept) mem[wr[AW-1:0]] <= {din_last, din};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr       <= '0;
      rd_ptr   <= '0;
      base_ptr <= '0;
    end else begin
      if (accept) wr <= wr + PW'(1);
      if (rewind) begin
        rd_ptr <= base_ptr;
      end else if (pop) begin
        rd_ptr <= rd_ptr + PW'(1);
        if (dout_last) base_ptr <= rd_ptr + PW'(1);
      end
    end
  end
endmodule

// File: rtl/ps2tx_frame.sv
`timescale 1ns/1ps
module ps2tx_frame
  import ps2tx_pkg::*;
#(
  parameter int HALF_US   = 40,
  parameter int CHANGE_US = 20,
  parameter int IDLE_US   = 50,
  parameter int GUARD_US  = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       clk_s,
  input  logic       dat_s,
  input  logic       have_byte,
  input  logic [7:0] byte_in,
  output logic       clk_oe,
  output logic       dat_oe,
  output logic       pop,
  output logic       rewind,
  output logic       frame_start,
  output logic       abort
);
  localparam int UW = $clog2(HALF_US + 1);
  localparam int IW = $clog2(IDLE_US + 1);
  localparam logic [UW-1:0] HALF_END = UW'(HALF_US - 1);
  localparam logic [UW-1:0] CHG_AT   = UW'(CHANGE_US - 1);
  localparam logic [UW-1:0] GUARD    = UW'(GUARD_US);
  localparam logic [IW-1:0] IDLE_MAX = IW'(IDLE_US);
  localparam logic [3:0]    LAST_BIT = 4'(FRAME_BITS - 1);

  tx_state_t             state;
  logic [UW-1:0]         us_cnt;
  logic [IW-1:0]         idle_cnt;
  logic [3:0]            bit_idx;
  logic [FRAME_BITS-1:0] shreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      us_cnt      <= '0;
      idle_cnt    <= '0;
      bit_idx     <= '0;
      shreg       <= '1;
      clk_oe      <= 1'b0;
      dat_oe      <= 1'b0;
      pop         <= 1'b0;
      rewind      <= 1'b0;
      frame_start <= 1'b0;
      abort       <= 1'b0;
    end else begin
      pop         <= 1'b0;
      rewind      <= 1'b0;
      frame_start <= 1'b0;
      abort       <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (!clk_s || !dat_s) begin
            idle_cnt <= '0;
          end else if (idle_cnt == IDLE_MAX && have_byte) begin
            shreg       <= build_frame(byte_in);
            bit_idx     <= '0;
            us_cnt      <= '0;
            idle_cnt    <= '0;
            frame_start <= 1'b1;
            state       <= ST_HIGH;
          end else if (tick && idle_cnt != IDLE_MAX) begin
            idle_cnt <= idle_cnt + IW'(1);
          end
        end
        ST_HIGH: begin
          if (us_cnt >= GUARD && !clk_s) begin
            abort    <= 1'b1;
            rewind   <= (bit_idx != 4'd0);
            dat_oe   <= 1'b0;
            idle_cnt <= '0;
            state    <= ST_IDLE;
          end else if (tick) begin
            if (us_cnt == HALF_END) begin
              clk_oe <= 1'b1;
              us_cnt <= '0;
              state  <= ST_LOW;
              if (bit_idx == LAST_BIT) pop <= 1'b1;
            end else begin
              if (us_cnt == CHG_AT) dat_oe <= ~shreg[0];
              us_cnt <= us_cnt + UW'(1);
            end
          end
        end
        ST_LOW: begin
          if (tick) begin
            if (us_cnt == HALF_END) begin
              clk_oe <= 1'b0;
              us_cnt <= '0;
              shreg  <= {1'b1, shreg[FRAME_BITS-1:1]};
              if (bit_idx == LAST_BIT) begin
                bit_idx <= '0;
                state   <= ST_IDLE;
              end else begin
                bit_idx <= bit_idx + 4'd1;
                state   <= ST_HIGH;
              end
            end else begin
              us_cnt <= us_cnt + UW'(1);
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ps2_dev_tx.sv
`timescale 1ns/1ps
module ps2_dev_tx #(
  parameter int CLKS_PER_US = 125,
  parameter int FIFO_DEPTH  = 16,
  parameter int HALF_US     = 40,
  parameter int CHANGE_US   = 20,
  parameter int IDLE_US     = 50,
  parameter int GUARD_US    = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] tx_byte,
  input  logic       tx_push,
  input  logic       tx_last,
  input  logic       ps2_clk_in,
  input  logic       ps2_dat_in,
  output logic       ps2_clk_oe,
  output logic       ps2_dat_oe,
  output logic       fifo_full
);
  localparam int PW = $clog2(FIFO_DEPTH) + 1;

  logic [1:0]    clk_sync, dat_sync;
  logic          clk_s, dat_s, tick;
  logic          have_byte, pop, rewind, frame_start, abort;
  logic [7:0]    head_byte;
  logic [PW-1:0] fill, rd_ptr, base_ptr;

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_sync <= 2'b11;
      dat_sync <= 2'b11;
    end else begin
      clk_sync <= {clk_sync[0], ps2_clk_in};
      dat_sync <= {dat_sync[0], ps2_dat_in};
    end
  end
  assign clk_s = clk_sync[1];
  assign dat_s = dat_sync[1];

  ps2tx_tick #(.CLKS_PER_US(CLKS_PER_US)) u_tick (
    .clk(clk), .rst(rst), .tick(tick)
  );

  ps2tx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(8)) u_fifo (
    .clk(clk), .rst(rst),
    .push(tx_push), .din(tx_byte), .din_last(tx_last),
    .pop(pop), .rewind(rewind),
    .dout(head_byte), .have_byte(have_byte), .full(fifo_full),
    .fill(fill), .rd_ptr(rd_ptr), .base_ptr(base_ptr)
  );

  ps2tx_frame #(
    .HALF_US(HALF_US), .CHANGE_US(CHANGE_US),
    .IDLE_US(IDLE_US), .GUARD_US(GUARD_US)
  ) u_frame (
    .clk(clk), .rst(rst), .tick(tick),
    .clk_s(clk_s), .dat_s(dat_s),
    .have_byte(have_byte), .byte_in(head_byte),
    .clk_oe(ps2_clk_oe), .dat_oe(ps2_dat_oe),
    .pop(pop), .rewind(rewind),
    .frame_start(frame_start), .abort(abort)
  );
endmodule

// File: rtl/ps2_dev_tx_chk.sv
`timescale 1ns/1ps
module ps2_dev_tx_chk #(
  parameter int DEPTH = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   clk_oe,
  input logic                   dat_oe,
  input logic                   clk_s,
  input logic                   dat_s,
  input logic                   push,
  input logic                   full,
  input logic                   pop,
  input logic                   rewind,
  input logic                   frame_start,
  input logic                   abort,
  input logic [$clog2(DEPTH):0] fill,
  input logic [$clog2(DEPTH):0] rd_ptr,
  input logic [$clog2(DEPTH):0] base_ptr
);
  localparam int PW = $clog2(DEPTH) + 1;
  localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

  p_dat_moves_clk_high_r7: assert property (@(posedge clk) disable iff (rst)
    !$stable(dat_oe) |-> (!clk_oe && !$past(clk_oe)));

  p_start_idle_bus_r4: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> ($past(clk_s) && $past(dat_s) && !clk_oe && !dat_oe));

  p_abort_releases_r8: assert property (@(posedge clk) disable iff (rst)
    abort |-> (!clk_oe && !dat_oe));

  p_rewind_to_base_r8: assert property (@(posedge clk) disable iff (rst)
    rewind |=> (rd_ptr == base_ptr));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    (full && push && !pop && !rewind) |=> (fill == DEPTH_P));

  p_commit_on_fall_r10: assert property (@(posedge clk) disable iff (rst)
    pop |-> clk_oe);
endmodule

bind ps2_dev_tx ps2_dev_tx_chk #(.DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst(rst),
  .clk_oe(ps2_clk_oe), .dat_oe(ps2_dat_oe),
  .clk_s(clk_s), .dat_s(dat_s),
  .push(tx_push), .full(fifo_full),
  .pop(pop), .rewind(rewind),
  .frame_start(frame_start), .abort(abort),
  .fill(fill), .rd_ptr(rd_ptr), .base_ptr(base_ptr)
);

// File: tb/ps2_dev_tx_bench.sv
`timescale 1ns/1ps
module ps2_dev_tx_bench;
  localparam int  CPU  = 2;
  localparam time TCLK = 8;
  localparam time HALF_NS = 40 * CPU * TCLK;
  localparam time CHG_NS  = 20 * CPU * TCLK;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [7:0] tx_byte = '0;
  logic tx_push = 1'b0, tx_last = 1'b0;
  logic host_clk_low = 1'b0;
  logic clk_oe, dat_oe, fifo_full;
  logic ps2_clk, ps2_dat;

  assign ps2_clk = ~(clk_oe | host_clk_low);
  assign ps2_dat = ~dat_oe;

  always #(TCLK/2) clk = ~clk;

  ps2_dev_tx #(.CLKS_PER_US(CPU)) u_ps2_dev_tx (
    .clk(clk), .rst(rst), .tx_byte(tx_byte), .tx_push(tx_push), .tx_last(tx_last),
    .ps2_clk_in(ps2_clk), .ps2_dat_in(ps2_dat),
    .ps2_clk_oe(clk_oe), .ps2_dat_oe(dat_oe), .fifo_full(fifo_full)
  );

  int checks = 0, failures = 0;
  bit done = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // host-side receiver model
  logic [7:0] rx_q [64];
  int rx_n = 0;
  int rx_bits = 0;
  logic [10:0] rx_sh;

  always @(posedge host_clk_low) rx_bits = 0;

  always @(negedge ps2_clk) begin
    if (!host_clk_low) begin
      rx_sh[rx_bits] = ps2_dat;
      rx_bits++;
      if (rx_bits == 11) begin
        check(rx_sh[0] == 1'b0, "R2", "start bit", rx_sh[0], 0);
        check(rx_sh[10] == 1'b1, "R2", "stop bit", rx_sh[10], 1);
        check((^rx_sh[9:1]) == 1'b1, "R2", "odd parity", rx_sh[9], ~^rx_sh[8:1]);
        if (rx_n < 64) rx_q[rx_n] = rx_sh[8:1];
        rx_n++;
        rx_bits = 0;
      end
    end
  end

  // timing of the first frame
  initial begin
    time t1, t2, t3, t4;
    @(posedge dat_oe); t1 = $time;
    @(posedge clk_oe); t2 = $time;
    check(t2 - t1 == CHG_NS, "R7", "start bit lead before fall (ns)", int'(t2 - t1), int'(CHG_NS));
    @(negedge clk_oe); t3 = $time;
    check(t3 - t2 == HALF_NS, "R6", "low phase (ns)", int'(t3 - t2), int'(HALF_NS));
    @(posedge clk_oe); t4 = $time;
    check(t4 - t3 == HALF_NS, "R6", "high phase (ns)", int'(t4 - t3), int'(HALF_NS));
  end

  task automatic push(input logic [7:0] b, input logic last);
    @(negedge clk);
    tx_byte = b; tx_last = last; tx_push = 1'b1;
    @(negedge clk);
    tx_push = 1'b0;
  endtask

  task automatic wait_rx(input int n, input string req);
    int cnt = 0;
    while (rx_n < n && cnt < 30000) begin
      @(negedge clk);
      cnt++;
    end
    check(rx_n >= n, req, "byte count reached", rx_n, n);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // {last, byte}
  localparam logic [8:0] VEC [7] = '{
    {1'b1, 8'h15}, {1'b0, 8'hF0}, {1'b1, 8'h1C}, {1'b1, 8'h00},
    {1'b1, 8'hFF}, {1'b1, 8'hA5}, {1'b1, 8'h80}
  };

  initial begin
    int base;
    host_clk_low = 1'b1;
    idle(5);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(clk_oe == 1'b0, "R1", "clk_oe after reset", clk_oe, 0);
    check(dat_oe == 1'b0, "R1", "dat_oe after reset", dat_oe, 0);
    check(fifo_full == 1'b0, "R1", "full after reset", fifo_full, 0);

    // R5 / R4: queued byte waits under inhibit, then qualification delay
    push(8'h3C, 1'b1);
    idle(1000);
    check(clk_oe == 1'b0 && dat_oe == 1'b0, "R5", "lines driven under inhibit",
          {clk_oe, dat_oe}, 0);
    host_clk_low = 1'b0;
    idle(130);
    check(dat_oe == 1'b0, "R4", "start before 50us idle", dat_oe, 0);
    wait_rx(1, "R4");
    check(rx_q[0] == 8'h3C, "R2", "first byte", rx_q[0], 8'h3C);

    // vector table walk: R2, R11
    for (int i = 0; i < 7; i++) begin
      push(VEC[i][7:0], VEC[i][8]);
      wait_rx(2 + i, "R11");
      check(rx_q[1 + i] == VEC[i][7:0], "R11", "table byte", rx_q[1 + i], VEC[i][7:0]);
    end
    idle(400);

    // R8: mid-frame inhibit during second byte replays whole chunk
    base = rx_n;
    push(8'h5A, 1'b0);
    push(8'hC3, 1'b1);
    wait_rx(base + 1, "R8");
    wait (rx_bits == 5);
    @(negedge clk);
    host_clk_low = 1'b1;
    idle(200);
    host_clk_low = 1'b0;
    wait_rx(base + 3, "R8");
    idle(4000);
    check(rx_n == base + 3, "R8", "bytes after replay", rx_n, base + 3);
    check(rx_q[base] == 8'h5A && rx_q[base + 1] == 8'h5A, "R8", "chunk head resent",
          rx_q[base + 1], 8'h5A);
    check(rx_q[base + 2] == 8'hC3, "R8", "chunk tail", rx_q[base + 2], 8'hC3);

    // R9: inhibit before first falling edge; earlier chunk not repeated
    base = rx_n;
    push(8'h96, 1'b1);
    @(posedge dat_oe);
    idle(3);
    host_clk_low = 1'b1;
    idle(200);
    check(dat_oe == 1'b0, "R9", "data released on abort", dat_oe, 0);
    host_clk_low = 1'b0;
    wait_rx(base + 1, "R9");
    idle(4000);
    check(rx_n == base + 1 && rx_q[base] == 8'h96, "R9", "single resend",
          rx_n, base + 1);

    // R10: inhibit right after eleventh fall of first chunk byte
    base = rx_n;
    push(8'h11, 1'b0);
    push(8'h22, 1'b1);
    wait_rx(base + 1, "R10");
    host_clk_low = 1'b1;
    idle(200);
    host_clk_low = 1'b0;
    wait_rx(base + 2, "R10");
    idle(4000);
    check(rx_n == base + 2, "R10", "no resend after last fall", rx_n, base + 2);
    check(rx_q[base + 1] == 8'h22, "R10", "second byte", rx_q[base + 1], 8'h22);

    // R3: fill to 16 under inhibit, extra pushes dropped
    base = rx_n;
    host_clk_low = 1'b1;
    idle(400);
    for (int i = 0; i < 15; i++) push(8'h40 + 8'(i), 1'b1);
    check(fifo_full == 1'b0, "R3", "full at 15", fifo_full, 0);
    push(8'h4F, 1'b1);
    check(fifo_full == 1'b1, "R3", "full at 16", fifo_full, 1);
    push(8'hEE, 1'b1);
    push(8'hDD, 1'b1);
    host_clk_low = 1'b0;
    wait_rx(base + 16, "R3");
    idle(4000);
    check(rx_n == base + 16, "R3", "dropped bytes not sent", rx_n, base + 16);
    for (int i = 0; i < 16; i++)
      check(rx_q[base + i] == 8'h40 + 8'(i), "R3", "queued order", rx_q[base + i],
            8'h40 + i);
    check(fifo_full == 1'b0, "R3", "full after drain", fifo_full, 0);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule